// File: doc/BRIEF.md
# Serial Link Power State Controller

This block decides the power state of a point-to-point serial link made of 20 data lanes and one forwarded clock lane. It watches a per-cycle transmit-valid strobe and a pending-traffic flag. It measures how busy the link is over a fixed window and narrows or widens the link with hysteresis. When the link stays idle it puts the link into one of two sleep depths, and it models the wake-up delay of each depth before senders may transmit again.

There are four states. Full width drives every data lane. Half width drives the low ten lanes and still carries data with no penalty. Clock-only standby keeps the forwarded clock and no data lanes. Off has every lane and the clock dark. Idle and wake timings are inputs, so firmware or a neighbouring block can tune them at run time. A permit input decides whether the deepest state may be used at all. Clearing the enable input pins the link at full width.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After reset the state is full width (code 0), all 20 lane enables and the clock lane enable are high, and transmit-ready is high.
- R2: The state code on `state_o` is 0 for full width, 1 for half width, 2 for clock-only standby and 3 for off. The lane mask is 20'hFFFFF in state 0, 20'h003FF (lanes 0 to 9) in state 1, and zero in states 2 and 3. The clock lane enable is low only in state 3.
- R3: A utilization window is 256 cycles long. It restarts on every state change and whenever power management is disabled. At the end of a window in full width, the link moves to half width if the count of valid cycles times 100 is no more than 40 times 256.
- R4: At the end of a window in half width, the link returns to full width if the valid count times 100 is at least the upper percentage times 256. The upper percentage is `up_pct_i` clamped to the range 80 to 90.
- R5: Width changes happen only at the last cycle of a window, never in the middle of one.
- R6: In full or half width, a cycle with neither valid nor pending traffic adds one to a saturating idle count, and any active cycle clears it. When the idle count reaches `idle_stby_i`, the link enters standby.
- R7: In standby, the link enters off when the idle count reaches `idle_off_i` and `deep_ok_i` is high. When `deep_ok_i` is low, it stays in standby.
- R8: In standby, a wake request loads a counter with `wake_stby_i`. A wake request is valid, pending, or power management disabled. The state code stays 2 and transmit-ready stays low until the counter has run out, which takes `wake_stby_i`+1 cycles after the request edge. The link then resumes in full width.
- R9: In off, a wake request loads the counter with `wake_off_i` instead, with the same timing rule, and the link resumes in full width.
- R10: While `pm_en_i` is low, the link goes to full width on the next cycle and never narrows or sleeps.
- R11: Transmit-ready is high exactly in states 0 and 1.

Port order and widths follow the default parameters `LANES`=20 and `CW`=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pm_en_i | input | 1 | Power management enable |
| tx_valid_i | input | 1 | A transfer is being sent this cycle |
| traffic_pend_i | input | 1 | Traffic is queued for the link |
| deep_ok_i | input | 1 | Permit to enter the off state |
| up_pct_i | input | 7 | Widen threshold in percent (clamped 80 to 90) |
| idle_stby_i | input | 16 | Idle cycles before standby |
| idle_off_i | input | 16 | Idle cycles before off |
| wake_stby_i | input | 16 | Wake latency from standby |
| wake_off_i | input | 16 | Wake latency from off |
| state_o | output | 2 | Current state code |
| lane_en_o | output | 20 | Data lane enables |
| clk_lane_en_o | output | 1 | Forwarded clock lane enable |
| tx_ready_o | output | 1 | Senders may transmit |

## Verification
The bench goes after four corner cases. The first is the mid-window point, where a design that decides width every cycle would narrow early. The second is a traffic level between 90 and 95 percent with the widen threshold programmed to 95, which only the clamp turns into a widen. The third is a long idle stretch in standby with the deep permit low, where a design that ignores the permit would go dark. The fourth is the wake interval from each sleep depth, where a swapped or unloaded latency would raise transmit-ready early or late. It also disables power management while the link is at half width, which a design that only blocks new decisions would leave narrow.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    LS_FULL = 2'd0,
    LS_HALF = 2'd1,
    LS_STBY = 2'd2,
    LS_OFF  = 2'd3
  } lstate_e;
endpackage

// File: rtl/lpc_util_meter.sv
module lpc_util_meter #(
  parameter int WIN = 256,
  localparam int IW = $clog2(WIN),
  localparam int BW = $clog2(WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          valid_i,
  output logic          win_end_o,
  output logic [BW-1:0] busy_sum_o
);
  logic [IW-1:0] win_q;
  logic [BW-1:0] busy_q;

  assign win_end_o  = (win_q == IW'(WIN - 1));
  assign busy_sum_o = busy_q + BW'(valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      busy_q <= '0;
    end else if (restart_i || win_end_o) begin
      win_q  <= '0;
      busy_q <= '0;
    end else begin
      win_q  <= win_q + 1'b1;
      busy_q <= busy_sum_o;
    end
  end
endmodule

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          act_i,
  output logic [CW-1:0] nxt_o
);
  logic [CW-1:0] cnt_q;

  // saturating increment
  assign nxt_o = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || act_i)  cnt_q <= '0;
    else                      cnt_q <= nxt_o;
  end
endmodule

// File: rtl/lpc_wake_timer.sv
module lpc_wake_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] lat_i,
  output logic          busy_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_i;
    end else if (expire_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lpc_lane_map.sv
module lpc_lane_map
  import lpc_pkg::*;
#(
  parameter int LANES = 20,
  localparam int HALF = LANES / 2
) (
  input  lstate_e          state_i,
  output logic [LANES-1:0] lane_en_o,
  output logic             clk_en_o
);
  logic full_w, half_w;
  assign full_w   = (state_i == LS_FULL);
  assign half_w   = (state_i == LS_HALF);
  assign clk_en_o = (state_i != LS_OFF);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < HALF) begin : g_low
      assign lane_en_o[g] = full_w || half_w;
    end else begin : g_high
      assign lane_en_o[g] = full_w;
    end
  end
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import lpc_pkg::*;
#(
  parameter int LANES    = 20,
  parameter int WIN      = 256,
  parameter int CW       = 16,
  parameter int DOWN_PCT = 40,
  parameter int UP_MIN   = 80,
  parameter int UP_MAX   = 90,
  localparam int BW      = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pm_en_i,
  input  logic             tx_valid_i,
  input  logic             traffic_pend_i,
  input  logic             deep_ok_i,
  input  logic [6:0]       up_pct_i,
  input  logic [CW-1:0]    idle_stby_i,
  input  logic [CW-1:0]    idle_off_i,
  input  logic [CW-1:0]    wake_stby_i,
  input  logic [CW-1:0]    wake_off_i,
  output logic [1:0]       state_o,
  output logic [LANES-1:0] lane_en_o,
  output logic             clk_lane_en_o,
  output logic             tx_ready_o
);
  localparam logic [31:0] DOWN_LIM = 32'(DOWN_PCT * WIN);

  lstate_e       state_q, state_d;
  logic          act, wake_req, restart;
  logic          win_end;
  logic [BW-1:0] busy_sum;
  logic [CW-1:0] idle_nxt;
  logic          wake_load, wake_busy, wake_exp;
  logic [CW-1:0] wake_lat;
  logic [6:0]    up_eff;
  logic [31:0]   busy_pct, up_lim;

  assign act      = tx_valid_i || traffic_pend_i;
  assign wake_req = act || !pm_en_i;

  always_comb begin
    if (up_pct_i < 7'(UP_MIN))      up_eff = 7'(UP_MIN);
    else if (up_pct_i > 7'(UP_MAX)) up_eff = 7'(UP_MAX);
    else                            up_eff = up_pct_i;
  end

  assign busy_pct = 32'(busy_sum) * 32'd100;
  assign up_lim   = 32'(up_eff) * 32'(WIN);

  always_comb begin
    state_d   = state_q;
    wake_load = 1'b0;
    wake_lat  = wake_stby_i;
    unique case (state_q)
      LS_FULL, LS_HALF: begin
        if (!pm_en_i) begin
          state_d = LS_FULL;
        end else if (!act && idle_nxt >= idle_stby_i) begin
          state_d = LS_STBY;
        end else if (win_end) begin
          if (state_q == LS_FULL && busy_pct <= DOWN_LIM)    state_d = LS_HALF;
          else if (state_q == LS_HALF && busy_pct >= up_lim) state_d = LS_FULL;
        end
      end
      LS_STBY: begin
        if (wake_busy) begin
          if (wake_exp) state_d = LS_FULL;
        end else if (wake_req) begin
          wake_load = 1'b1;
        end else if (deep_ok_i && idle_nxt >= idle_off_i) begin
          state_d = LS_OFF;
        end
      end
      LS_OFF: begin
        wake_lat = wake_off_i;
        if (wake_busy) begin
          if (wake_exp) state_d = LS_FULL;
        end else if (wake_req) begin
          wake_load = 1'b1;
        end
      end
      default: state_d = LS_FULL;
    endcase
  end

  assign restart = (state_d != state_q) || (state_q == LS_STBY) ||
                   (state_q == LS_OFF) || !pm_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_FULL;
    else         state_q <= state_d;
  end

  lpc_util_meter #(.WIN(WIN)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .valid_i    (tx_valid_i),
    .win_end_o  (win_end),
    .busy_sum_o (busy_sum)
  );

  lpc_idle_timer #(.CW(CW)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!pm_en_i || wake_exp),
    .act_i  (act),
    .nxt_o  (idle_nxt)
  );

  lpc_wake_timer #(.CW(CW)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wake_load),
    .lat_i    (wake_lat),
    .busy_o   (wake_busy),
    .expire_o (wake_exp)
  );

  lpc_lane_map #(.LANES(LANES)) u_map (
    .state_i   (state_q),
    .lane_en_o (lane_en_o),
    .clk_en_o  (clk_lane_en_o)
  );

  assign state_o    = state_q;
  assign tx_ready_o = (state_q == LS_FULL) || (state_q == LS_HALF);
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int LANES = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pm_en_i,
  input logic             tx_valid_i,
  input logic             traffic_pend_i,
  input logic             deep_ok_i,
  input logic [1:0]       state_o,
  input logic [LANES-1:0] lane_en_o,
  input logic             clk_lane_en_o,
  input logic             tx_ready_o
);
  localparam logic [LANES-1:0] HALF_MASK = ~({LANES{1'b1}} << (LANES / 2));

  p_half_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 |-> lane_en_o == HALF_MASK);

  p_off_dark_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |-> (!clk_lane_en_o && lane_en_o == '0));

  p_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o == (state_o < 2'd2));

  p_pm_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_en_i && state_o < 2'd2) |=> state_o == 2'd0);

  p_deep_permit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && $past(state_o) != 2'd3) |-> $past(deep_ok_i));

  p_sleep_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |->
      ($past(state_o) < 2'd2 && !$past(tx_valid_i) && !$past(traffic_pend_i)));

  p_wake_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) >= 2'd2 && state_o < 2'd2) |-> state_o == 2'd0);
endmodule

bind link_pwr_ctrl lpc_checker #(.LANES(LANES)) u_lpc_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pm_en_i        (pm_en_i),
  .tx_valid_i     (tx_valid_i),
  .traffic_pend_i (traffic_pend_i),
  .deep_ok_i      (deep_ok_i),
  .state_o        (state_o),
  .lane_en_o      (lane_en_o),
  .clk_lane_en_o  (clk_lane_en_o),
  .tx_ready_o     (tx_ready_o)
);

// File: tb/link_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module link_pwr_ctrl_bench;
  localparam int WIN  = 256;
  localparam int IMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_en = 1'b1, tx_valid = 1'b0, pend = 1'b0, deep_ok = 1'b0;
  logic [6:0]  up_pct = 7'd85;
  logic [15:0] idle_stby = 16'd20, idle_off = 16'd60;
  logic [15:0] wake_stby = 16'd5, wake_off = 16'd40;
  logic [1:0]  state;
  logic [19:0] lane_en;
  logic        clk_en, tx_ready;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  link_pwr_ctrl u_link_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pm_en_i(pm_en), .tx_valid_i(tx_valid),
    .traffic_pend_i(pend), .deep_ok_i(deep_ok), .up_pct_i(up_pct),
    .idle_stby_i(idle_stby), .idle_off_i(idle_off),
    .wake_stby_i(wake_stby), .wake_off_i(wake_off),
    .state_o(state), .lane_en_o(lane_en), .clk_lane_en_o(clk_en),
    .tx_ready_o(tx_ready)
  );

  // behavioural reference
  int m_state, m_win, m_busy, m_idle, m_wake;
  bit m_waking;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_win = 0; m_busy = 0; m_idle = 0; m_wake = 0; m_waking = 0;
    end else begin
      bit act, wreq, exp_w, load;
      int idle_n, busy_n, up, nxt, lat;
      act    = tx_valid || pend;
      wreq   = act || !pm_en;
      idle_n = (m_idle >= IMAX) ? IMAX : m_idle + 1;
      exp_w  = m_waking && (m_wake == 0);
      busy_n = m_busy + int'(tx_valid);
      up     = (up_pct < 80) ? 80 : (up_pct > 90) ? 90 : int'(up_pct);
      nxt = m_state; load = 0; lat = 0;
      if (m_state < 2) begin
        if (!pm_en) nxt = 0;
        else if (!act && idle_n >= idle_stby) nxt = 2;
        else if (m_win == WIN - 1) begin
          if (m_state == 0 && busy_n * 100 <= 40 * WIN) nxt = 1;
          else if (m_state == 1 && busy_n * 100 >= up * WIN) nxt = 0;
        end
      end else if (m_waking) begin
        if (exp_w) nxt = 0;
      end else if (wreq) begin
        load = 1; lat = (m_state == 2) ? int'(wake_stby) : int'(wake_off);
      end else if (m_state == 2 && deep_ok && idle_n >= idle_off) nxt = 3;

      if (nxt != m_state || m_state >= 2 || !pm_en || m_win == WIN - 1) begin
        m_win = 0; m_busy = 0;
      end else begin
        m_win++; m_busy = busy_n;
      end
      if (!pm_en || act || exp_w) m_idle = 0; else m_idle = idle_n;
      if (load) begin m_waking = 1; m_wake = lat; end
      else if (exp_w) m_waking = 0;
      else if (m_waking) m_wake--;
      m_state = nxt;
    end
  end

  function automatic logic [19:0] ref_mask(int s);
    return (s == 0) ? 20'hFFFFF : (s == 1) ? 20'h003FF : 20'h0;
  endfunction

  task automatic check(string req, string what, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, "state", int'(state), m_state);
    check(cur_req, "lanes", int'(lane_en), int'(ref_mask(m_state)));
    check(cur_req, "clk lane", int'(clk_en), int'(m_state != 3));
    check("R11", "ready", int'(tx_ready), int'(m_state < 2));
  end

  task automatic drive(int n, int period, int on_cnt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_valid = ((i % period) < on_cnt);
      pend = 1'b0;
    end
  endtask

  task automatic pulse_pend();
    @(negedge clk); tx_valid = 1'b0; pend = 1'b1;
    @(negedge clk); pend = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "reset state", int'(state), 0);
    check("R1", "reset lanes", int'(lane_en), 'hFFFFF);
    check("R1", "reset clk", int'(clk_en), 1);
    check("R1", "reset ready", int'(tx_ready), 1);

    cur_req = "R5";
    drive(127, 10, 3);
    check("R5", "mid-window width", int'(state), 0);
    cur_req = "R3";
    drive(172, 10, 3);
    check("R3", "narrowed", int'(state), 1);
    check("R2", "half mask", int'(lane_en), 'h003FF);

    cur_req = "R4";
    up_pct = 7'd95;  // clamped to 90
    drive(600, 12, 11);
    check("R4", "widened via clamp", int'(state), 0);
    up_pct = 7'd85;

    cur_req = "R6";
    drive(25, 1, 0);
    check("R6", "standby", int'(state), 2);
    check("R2", "standby lanes", int'(lane_en), 0);
    check("R2", "standby clk", int'(clk_en), 1);
    cur_req = "R7";
    drive(100, 1, 0);
    check("R7", "no permit stays standby", int'(state), 2);

    cur_req = "R8";
    pulse_pend();
    drive(3, 1, 0);
    check("R8", "waking ready", int'(tx_ready), 0);
    check("R8", "waking state", int'(state), 2);
    drive(8, 1, 0);
    check("R8", "woke to full", int'(state), 0);

    cur_req = "R7";
    deep_ok = 1'b1;
    drive(100, 1, 0);
    check("R7", "off", int'(state), 3);
    check("R2", "off clk", int'(clk_en), 0);

    cur_req = "R9";
    pulse_pend();
    drive(20, 1, 0);
    check("R9", "waking from off", int'(state), 3);
    check("R9", "waking ready", int'(tx_ready), 0);
    drive(30, 1, 0);
    check("R9", "woke to full", int'(state), 0);
    deep_ok = 1'b0;

    cur_req = "R10";
    drive(600, 10, 3);
    check("R3", "narrowed again", int'(state), 1);
    pm_en = 1'b0;
    drive(2, 10, 3);
    check("R10", "disable forces full", int'(state), 0);
    drive(700, 10, 1);
    drive(100, 1, 0);
    check("R10", "disabled stays full", int'(state), 0);
    check("R10", "disabled lanes", int'(lane_en), 'hFFFFF);
    pm_en = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule